// File: doc/BRIEF.md
# Vector Length Setting Unit

This unit carries out the instruction that sets the maximum vector length (MVL) and the current vector length (VL). The decoder supplies the instruction fields: a 7-bit immediate, the set-max, set-length and vertical-first mode bits, the destination and source register numbers, and the record bit. The register file and special registers supply the source operand value, the count register (CTR) value and the current 64-bit vector state word. The unit picks the source for the new length and saturates it to the 7-bit range. It then clamps the length to the new MVL and records any overflow. One cycle later it returns the rewritten state word, an optional general-register writeback and an optional condition field. Each of these three results has its own write strobe.

The length can come from the immediate, from the source operand or from CTR. The choice depends on whether the source and destination register numbers are zero. Overflow reaches the condition field even when no register is written.

Bit positions below use LSB-0 numbering of the 64-bit state word. The MVL field is bits [63:57], the VL field is bits [56:50], the persistence bit is bit 1 and the vertical-first bit is bit 0.

Top module: `veclen_unit`

## Requirements
- R1: The effective immediate is imm_i + 1 truncated to 7 bits, so an encoded 0 means 1 and an encoded 127 means 0.
- R2: With set_max_i=1 the new MVL is the effective immediate. With set_max_i=0 it is state_i[63:57].
- R3: With set_len_i=0 the candidate VL is state_i[56:50] and no overflow comes from the source.
- R4: With set_len_i=1 and ra_idx_i≠0 the candidate VL is ra_val_i. A value above 127 (unsigned) gives 127 and flags overflow.
- R5: With set_len_i=1, ra_idx_i=0 and rt_idx_i=0 the candidate VL is the effective immediate.
- R6: With set_len_i=1, ra_idx_i=0 and rt_idx_i≠0 the candidate VL is ctr_i. A value above 127 gives 127 and flags overflow.
- R7: A candidate VL greater than the new MVL is replaced by the MVL and flags overflow.
- R8: state_we_o is asserted when set_max_i or set_len_i is 1. state_o carries the new MVL in [63:57] and the new VL in [56:50], with bits [49:2] copied from state_i.
- R9: With set_max_i=1, state_o[0] equals vert_i and state_o[1] is 0. Otherwise both bits are copied from state_i.
- R10: gpr_we_o is asserted when rt_idx_i≠0. gpr_idx_o is then rt_idx_i and gpr_data_o is the new VL zero-extended to 64 bits.
- R11: cr_we_o equals rec_i. cr_o is {LT,GT,EQ,SO}, with LT=0, GT=(VL≠0), EQ=(VL=0) and SO=overflow.
- R12: All results appear one clock after valid_i with valid_o=1. Without valid_i, valid_o and all strobes are 0. All are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present |
| imm_i | input | 7 | Encoded length immediate |
| set_max_i | input | 1 | Load MVL from immediate |
| set_len_i | input | 1 | Load VL from selected source |
| vert_i | input | 1 | Vertical-first mode value |
| rt_idx_i | input | 5 | Destination register number |
| ra_idx_i | input | 5 | Source register number |
| rec_i | input | 1 | Record condition field |
| ra_val_i | input | 64 | Source register value |
| ctr_i | input | 64 | Count register value |
| state_i | input | 64 | Current vector state word |
| valid_o | output | 1 | Results valid |
| state_we_o | output | 1 | State word write strobe |
| state_o | output | 64 | New state word |
| gpr_we_o | output | 1 | Register writeback strobe |
| gpr_idx_o | output | 5 | Writeback register number |
| gpr_data_o | output | 64 | Writeback value |
| cr_we_o | output | 1 | Condition field write strobe |
| cr_o | output | 4 | Condition field {LT,GT,EQ,SO} |

## Verification
The sweep covers every combination of the mode bits, zero and nonzero register numbers, and the record bit. Each combination is tried against operand values at 0, inside the range, at 127, at 128 and far above, and against prior states whose MVL is small, large or zero. Operand values at 127 and 128 separate saturation from plain pass-through. A small MVL separates clamping from source selection. Giving the source operand and CTR different values shows which of the two sources was picked. Immediates of 0 and 127 expose the add-one wrap.

// File: rtl/veclen_pkg.sv
package veclen_pkg;
  parameter int unsigned XLEN  = 64;
  parameter int unsigned LEN_W = 7;
  parameter int unsigned REG_W = 5;
  localparam int unsigned MVL_HI = XLEN - 1;
  localparam int unsigned VL_HI  = XLEN - 1 - LEN_W;
  localparam int unsigned VL_LO  = XLEN - 2 * LEN_W;
  localparam int unsigned PST_BIT = 1;
  localparam int unsigned VF_BIT  = 0;

  typedef enum logic [1:0] {
    SRC_KEEP = 2'd0,
    SRC_IMM  = 2'd1,
    SRC_REG  = 2'd2,
    SRC_CTR  = 2'd3
  } len_src_e;
endpackage

// File: rtl/veclen_src.sv
module veclen_src
  import veclen_pkg::*;
#(
  parameter int unsigned W = XLEN,
  parameter int unsigned L = LEN_W
) (
  input  len_src_e     sel_i,
  input  logic [L-1:0] keep_i,
  input  logic [L-1:0] imm_i,
  input  logic [W-1:0] reg_i,
  input  logic [W-1:0] ctr_i,
  output logic [L-1:0] len_o,
  output logic         sat_o
);
  localparam logic [W-1:0] LIMIT = W'((1 << L) - 1);

  logic [W-1:0] wide;
  logic         big;

  always_comb begin
    wide = (sel_i == SRC_REG) ? reg_i : ctr_i;
    big  = wide > LIMIT;
    len_o = keep_i;
    sat_o = 1'b0;
    unique case (sel_i)
      SRC_KEEP: len_o = keep_i;
      SRC_IMM:  len_o = imm_i;
      default: begin
        len_o = big ? L'(LIMIT) : wide[L-1:0];
        sat_o = big;
      end
    endcase
  end
endmodule

// File: rtl/veclen_clamp.sv
module veclen_clamp #(
  parameter int unsigned L = 7
) (
  input  logic [L-1:0] len_i,
  input  logic [L-1:0] max_i,
  output logic [L-1:0] len_o,
  output logic         cut_o
);
  always_comb begin
    cut_o = len_i > max_i;
    len_o = cut_o ? max_i : len_i;
  end
endmodule

// File: rtl/veclen_unit.sv
module veclen_unit
  import veclen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [LEN_W-1:0] imm_i,
  input  logic             set_max_i,
  input  logic             set_len_i,
  input  logic             vert_i,
  input  logic [REG_W-1:0] rt_idx_i,
  input  logic [REG_W-1:0] ra_idx_i,
  input  logic             rec_i,
  input  logic [XLEN-1:0]  ra_val_i,
  input  logic [XLEN-1:0]  ctr_i,
  input  logic [XLEN-1:0]  state_i,
  output logic             valid_o,
  output logic             state_we_o,
  output logic [XLEN-1:0]  state_o,
  output logic             gpr_we_o,
  output logic [REG_W-1:0] gpr_idx_o,
  output logic [XLEN-1:0]  gpr_data_o,
  output logic             cr_we_o,
  output logic [3:0]       cr_o
);
  logic [LEN_W-1:0] eff_imm, new_mvl, cand_vl, new_vl;
  logic             sat_ovf, clamp_ovf, ovf;
  len_src_e         src_sel;
  logic [XLEN-1:0]  state_nx;

  // wrap is intentional: encoded max yields zero length
  assign eff_imm = imm_i + LEN_W'(1);
  assign new_mvl = set_max_i ? eff_imm : state_i[MVL_HI -: LEN_W];

  always_comb begin
    if (!set_len_i)            src_sel = SRC_KEEP;
    else if (ra_idx_i != '0)   src_sel = SRC_REG;
    else if (rt_idx_i == '0)   src_sel = SRC_IMM;
    else                       src_sel = SRC_CTR;
  end

  veclen_src #(.W(XLEN), .L(LEN_W)) i_src (
    .sel_i  (src_sel),
    .keep_i (state_i[VL_HI -: LEN_W]),
    .imm_i  (eff_imm),
    .reg_i  (ra_val_i),
    .ctr_i  (ctr_i),
    .len_o  (cand_vl),
    .sat_o  (sat_ovf)
  );

  veclen_clamp #(.L(LEN_W)) i_clamp (
    .len_i (cand_vl),
    .max_i (new_mvl),
    .len_o (new_vl),
    .cut_o (clamp_ovf)
  );

  assign ovf = sat_ovf | clamp_ovf;

  always_comb begin
    state_nx = state_i;
    if (set_max_i || set_len_i) begin
      state_nx[MVL_HI -: LEN_W] = new_mvl;
      state_nx[VL_HI -: LEN_W]  = new_vl;
    end
    if (set_max_i) begin
      state_nx[VF_BIT]  = vert_i;
      state_nx[PST_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      state_we_o <= 1'b0;
      gpr_we_o   <= 1'b0;
      cr_we_o    <= 1'b0;
      state_o    <= '0;
      gpr_idx_o  <= '0;
      gpr_data_o <= '0;
      cr_o       <= '0;
    end else begin
      valid_o    <= valid_i;
      state_we_o <= valid_i & (set_max_i | set_len_i);
      gpr_we_o   <= valid_i & (rt_idx_i != '0);
      cr_we_o    <= valid_i & rec_i;
      if (valid_i) begin
        state_o    <= state_nx;
        gpr_idx_o  <= rt_idx_i;
        gpr_data_o <= XLEN'(new_vl);
        cr_o       <= {1'b0, new_vl != '0, new_vl == '0, ovf};
      end
    end
  end

  // R7
  vl_within_mvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_we_o |-> state_o[VL_HI -: LEN_W] <= state_o[MVL_HI -: LEN_W]);
  // R2
  mvl_from_imm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && set_max_i |=> state_o[MVL_HI -: LEN_W] == LEN_W'($past(imm_i) + 1'b1));
  // R3
  hold_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !set_max_i && !set_len_i |=> !state_we_o && state_o == $past(state_i));
  // R9
  mode_bits_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !set_max_i |=> state_o[1:0] == $past(state_i[1:0]));
  // R10
  gpr_zero_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpr_we_o |-> gpr_data_o[XLEN-1:LEN_W] == '0 && gpr_idx_o != '0);
  // R11
  cr_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_we_o |-> !cr_o[3] && (cr_o[2] != cr_o[1]));
  // R12
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !state_we_o && !gpr_we_o && !cr_we_o);
endmodule

// File: tb/test_veclen_unit.sv
module test_veclen_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic valid_i = 1'b0, set_max, set_len, vert, rec;
  logic [6:0] imm;
  logic [4:0] rt_idx, ra_idx;
  logic [63:0] ra_val, ctr, state;
  logic valid_o, state_we, gpr_we, cr_we;
  logic [63:0] state_o, gpr_data;
  logic [4:0] gpr_idx;
  logic [3:0] cr;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  veclen_unit i_veclen_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .imm_i(imm),
    .set_max_i(set_max), .set_len_i(set_len), .vert_i(vert),
    .rt_idx_i(rt_idx), .ra_idx_i(ra_idx), .rec_i(rec),
    .ra_val_i(ra_val), .ctr_i(ctr), .state_i(state),
    .valid_o(valid_o), .state_we_o(state_we), .state_o(state_o),
    .gpr_we_o(gpr_we), .gpr_idx_o(gpr_idx), .gpr_data_o(gpr_data),
    .cr_we_o(cr_we), .cr_o(cr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [63:0] e_state;
  logic        e_swe, e_gwe, e_cwe;
  logic [3:0]  e_cr;
  int          e_vl;

  task automatic model();
    int eff, mvl, vl, ovf;
    eff = (int'(imm) + 1) % 128;                       // R1
    mvl = set_max ? eff : int'(state[63:57]);          // R2
    ovf = 0;
    if (!set_len) vl = int'(state[56:50]);             // R3
    else if (ra_idx != 0) begin                        // R4
      if (ra_val > 64'd127) begin vl = 127; ovf = 1; end else vl = int'(ra_val);
    end else if (rt_idx == 0) vl = eff;                // R5
    else begin                                         // R6
      if (ctr > 64'd127) begin vl = 127; ovf = 1; end else vl = int'(ctr);
    end
    if (vl > mvl) begin vl = mvl; ovf = 1; end         // R7
    e_vl = vl;
    e_state = state;
    e_swe = set_max | set_len;
    if (e_swe) begin e_state[63:57] = 7'(mvl); e_state[56:50] = 7'(vl); end
    if (set_max) begin e_state[0] = vert; e_state[1] = 1'b0; end
    e_gwe = rt_idx != 0;
    e_cwe = rec;
    e_cr = {1'b0, vl != 0, vl == 0, ovf[0]};
  endtask

  task automatic apply();
    model();
    valid_i = 1'b1;
    @(negedge clk);
    chk("R12 valid", 64'(valid_o), 64'd1);
    chk("R1 R2 mvl field", 64'(state_o[63:57]), e_state[63:57]);
    chk("R3 R4 R5 R6 R7 vl field", 64'(state_o[56:50]), e_state[56:50]);
    chk("R8 R9 state word", state_o, e_state);
    chk("R8 state strobe", 64'(state_we), 64'(e_swe));
    chk("R10 gpr strobe", 64'(gpr_we), 64'(e_gwe));
    if (e_gwe) begin
      chk("R10 gpr idx", 64'(gpr_idx), 64'(rt_idx));
      chk("R10 gpr data", gpr_data, 64'(e_vl));
    end
    chk("R11 cr strobe", 64'(cr_we), 64'(e_cwe));
    if (e_cwe) chk("R11 cr value", 64'(cr), 64'(e_cr));
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog R12 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] vals [5];
    logic [6:0]  imms [4];
    logic [63:0] sts  [3];
    vals = '{64'd0, 64'd5, 64'd127, 64'd128, 64'hFFFF_0000_0000_1234};
    imms = '{7'd0, 7'd9, 7'd126, 7'd127};
    sts  = '{{7'd4, 7'd2, 48'hA5A5_5A5A_C3C3, 2'b11},
             {7'd100, 7'd90, 48'h1234_5678_9ABC, 2'b10},
             {7'd0, 7'd0, 48'hFFFF_0000_FFFF, 2'b01}};
    {set_max, set_len, vert, rec} = '0;
    imm = '0; rt_idx = '0; ra_idx = '0; ra_val = '0; ctr = '0; state = '0;
    repeat (2) @(negedge clk);
    // R12 reset state
    chk("R12 reset valid", 64'(valid_o), 64'd0);
    chk("R12 reset strobes", 64'({state_we, gpr_we, cr_we}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 64; m++)
      for (int s = 0; s < 3; s++)
        for (int i = 0; i < 4; i++)
          for (int v = 0; v < 5; v++) begin
            {set_max, set_len, vert, rec} = m[3:0];
            ra_idx = m[4] ? 5'd7 : 5'd0;
            rt_idx = m[5] ? 5'd12 : 5'd0;
            state  = sts[s];
            imm    = imms[i];
            ra_val = vals[v];
            ctr    = vals[4 - v];
            apply();
          end
    // R12 no valid: no strobes
    valid_i = 1'b0; set_max = 1'b1; set_len = 1'b1; rt_idx = 5'd3; rec = 1'b1;
    @(negedge clk);
    chk("R12 idle valid", 64'(valid_o), 64'd0);
    chk("R12 idle strobes", 64'({state_we, gpr_we, cr_we}), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule